// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block changes the divider settings of one PLL in an order that never lets the rest of the chip see a clock from a half-configured loop. A request supplies the wanted reference divider (NR), feedback multiplier (NF) and output divider (NO). The sequencer first moves the PLL output onto the oscillator and holds the loop in reset. It then writes the divider fields and the bandwidth-adjust field, and waits a fixed number of reference cycles for the loop to settle. After that it releases reset, waits for the lock indication, and only then selects the PLL output. The resulting frequency is 24 MHz × NF / (NR × NO).

The handshake is a one-cycle `start` with the targets, a `busy` level for the length of the sequence, and a one-cycle `done` pulse when it ends. The lock wait is bounded by a timeout given with the request. If that timeout runs out, the sequence ends with `err` set and the output left on the oscillator.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset: `busy`, `done`, `err` and `pll_reset` are 0; `pll_mode` is 2'b00 (oscillator bypass); all divider and bandwidth fields are 0. Mode encoding: 2'b00 bypass, 2'b01 PLL output, 2'b10 low-frequency 32.768 kHz source. The block drives only 2'b00 and 2'b01.
- R2: On the clock edge that accepts `start` while idle, `busy` rises, `pll_mode` becomes 2'b00, `pll_reset` rises, `err` clears, and no divider field changes on that edge.
- R3: On the next edge, with `pll_reset` still 1, the fields become NR-1, NF-1 and NO-1 of the values presented with `start`. Divider fields change only while `pll_reset` is 1.
- R4: The bandwidth field is written on the same edge as the dividers, with the value (NF >> 1) - 1.
- R5: `pll_reset` stays 1 for exactly SETTLE_CYC cycles after the fields are written (default 240, which is 10 µs at 24 MHz), then falls.
- R6: After reset release, if `pll_lock` is sampled high on the k-th edge (k ≤ T+1, where T is the `lock_timeout` given with the request), then on that edge `pll_mode` becomes 2'b01, `done` pulses and `busy` falls. `pll_mode` never becomes 2'b01 unless lock was high on the previous sample and reset is released.
- R7: If lock is not seen by the (T+1)-th edge after release, then on that edge `err` rises, `done` pulses, `busy` falls and `pll_mode` stays 2'b00. `err` holds until the next accepted `start`.
- R8: A `start` that arrives while `busy` is 1 is ignored: the fields and the sequence timing are unaffected.
- R9: `done` lasts one cycle and is never high together with `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, accepted only when idle |
| nr_in | input | NR_W | Target reference divider (≥ 1) |
| nf_in | input | NF_W | Target feedback multiplier (≥ 2) |
| no_in | input | NO_W | Target output divider (≥ 1) |
| lock_timeout | input | TO_W | Lock wait limit in cycles |
| pll_lock | input | 1 | Lock status from the PLL |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err | output | 1 | Last sequence timed out waiting for lock |
| pll_mode | output | 2 | Output clock source select |
| pll_reset | output | 1 | PLL reset |
| pll_nr_field | output | NR_W | Reference divider field (value - 1) |
| pll_nf_field | output | NF_W | Feedback multiplier field (value - 1) |
| pll_no_field | output | NO_W | Output divider field (value - 1) |
| pll_bw_field | output | NF_W-1 | Bandwidth-adjust field |

## Verification
The properties assume non-zero NR and NO and an NF of at least 2. Under those conditions the minus-one encodings and the bandwidth value stay in range, and the field-consistency check holds. They also assume `pll_lock` is synchronous to `clk`. The stimulus presents only legal targets. Its lock model is a counter that clears while `pll_reset` is high, so lock can never appear during reset. The lock delay and the timeout are swept on both sides of each other, and equal values are included.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    typedef enum logic [1:0] {
        MODE_BYPASS = 2'd0,
        MODE_PLL    = 2'd1,
        MODE_LOWFRQ = 2'd2
    } pll_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ENTER  = 2'd1,
        ST_SETTLE = 2'd2,
        ST_LOCK   = 2'd3
    } seq_state_e;

endpackage

// File: rtl/pll_field_enc.sv
module pll_field_enc #(
    parameter int NR_W = 6,
    parameter int NF_W = 13,
    parameter int NO_W = 4,
    localparam int BW_W = NF_W - 1
) (
    input  logic [NR_W-1:0] nr_val,
    input  logic [NF_W-1:0] nf_val,
    input  logic [NO_W-1:0] no_val,
    output logic [NR_W-1:0] nr_code,
    output logic [NF_W-1:0] nf_code,
    output logic [NO_W-1:0] no_code,
    output logic [BW_W-1:0] bw_code
);

    // each divider is stored as its value minus one
    always_comb begin
        nr_code = nr_val - {{(NR_W-1){1'b0}}, 1'b1};
        nf_code = nf_val - {{(NF_W-1){1'b0}}, 1'b1};
        no_code = no_val - {{(NO_W-1){1'b0}}, 1'b1};
        // half the multiplier, minus one, for nominal loop bandwidth
        bw_code = nf_val[NF_W-1:1] - {{(BW_W-1){1'b0}}, 1'b1};
    end

endmodule

// File: rtl/pll_delay_cnt.sv
module pll_delay_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic         hit
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (en)
            cnt_d = cnt_q + {{(W-1){1'b0}}, 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign hit = en && (cnt_q == limit);

endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
    import pll_seq_pkg::*;
#(
    parameter int NR_W       = 6,
    parameter int NF_W       = 13,
    parameter int NO_W       = 4,
    parameter int TO_W       = 16,
    parameter int SETTLE_CYC = 240
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [NR_W-1:0] nr_in,
    input  logic [NF_W-1:0] nf_in,
    input  logic [NO_W-1:0] no_in,
    input  logic [TO_W-1:0] lock_timeout,
    input  logic            pll_lock,
    output logic            busy,
    output logic            done,
    output logic            err,
    output logic [1:0]      pll_mode,
    output logic            pll_reset,
    output logic [NR_W-1:0] pll_nr_field,
    output logic [NF_W-1:0] pll_nf_field,
    output logic [NO_W-1:0] pll_no_field,
    output logic [NF_W-2:0] pll_bw_field
);

    localparam int BW_W  = NF_W - 1;
    localparam int SET_W = $clog2(SETTLE_CYC + 1);
    localparam int CNT_W = (SET_W > TO_W) ? SET_W : TO_W;
    localparam logic [CNT_W-1:0] SETTLE_LIM = CNT_W'(SETTLE_CYC - 1);

    typedef struct packed {
        seq_state_e      st;
        logic            busy;
        logic            done;
        logic            err;
        logic            rst;
        pll_mode_e       mode;
        logic [NR_W-1:0] nr_t;
        logic [NF_W-1:0] nf_t;
        logic [NO_W-1:0] no_t;
        logic [TO_W-1:0] to_t;
        logic [NR_W-1:0] nr_f;
        logic [NF_W-1:0] nf_f;
        logic [NO_W-1:0] no_f;
        logic [BW_W-1:0] bw_f;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic [NR_W-1:0]  enc_nr;
    logic [NF_W-1:0]  enc_nf;
    logic [NO_W-1:0]  enc_no;
    logic [BW_W-1:0]  enc_bw;
    logic             cnt_clr, cnt_en, cnt_hit;
    logic [CNT_W-1:0] cnt_lim;

    pll_field_enc #(.NR_W(NR_W), .NF_W(NF_W), .NO_W(NO_W)) u_enc (
        .nr_val  (r_q.nr_t),
        .nf_val  (r_q.nf_t),
        .no_val  (r_q.no_t),
        .nr_code (enc_nr),
        .nf_code (enc_nf),
        .no_code (enc_no),
        .bw_code (enc_bw)
    );

    pll_delay_cnt #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .en    (cnt_en),
        .limit (cnt_lim),
        .hit   (cnt_hit)
    );

    always_comb begin
        r_d     = r_q;
        r_d.done = 1'b0;
        cnt_clr = 1'b0;
        cnt_en  = 1'b0;
        cnt_lim = SETTLE_LIM;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st   = ST_ENTER;
                    r_d.busy = 1'b1;
                    r_d.err  = 1'b0;
                    r_d.rst  = 1'b1;
                    r_d.mode = MODE_BYPASS;
                    r_d.nr_t = nr_in;
                    r_d.nf_t = nf_in;
                    r_d.no_t = no_in;
                    r_d.to_t = lock_timeout;
                end
            end
            ST_ENTER: begin
                // bypass and reset are already in effect
                r_d.nr_f = enc_nr;
                r_d.nf_f = enc_nf;
                r_d.no_f = enc_no;
                r_d.bw_f = enc_bw;
                r_d.st   = ST_SETTLE;
                cnt_clr  = 1'b1;
            end
            ST_SETTLE: begin
                cnt_en = 1'b1;
                if (cnt_hit) begin
                    r_d.rst = 1'b0;
                    r_d.st  = ST_LOCK;
                    cnt_clr = 1'b1;
                end
            end
            ST_LOCK: begin
                cnt_en  = 1'b1;
                cnt_lim = CNT_W'(r_q.to_t);
                if (pll_lock) begin
                    r_d.mode = MODE_PLL;
                    r_d.done = 1'b1;
                    r_d.busy = 1'b0;
                    r_d.st   = ST_IDLE;
                    cnt_clr  = 1'b1;
                end else if (cnt_hit) begin
                    r_d.err  = 1'b1;
                    r_d.done = 1'b1;
                    r_d.busy = 1'b0;
                    r_d.st   = ST_IDLE;
                    cnt_clr  = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.mode <= MODE_BYPASS;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy         = r_q.busy;
    assign done         = r_q.done;
    assign err          = r_q.err;
    assign pll_mode     = r_q.mode;
    assign pll_reset    = r_q.rst;
    assign pll_nr_field = r_q.nr_f;
    assign pll_nf_field = r_q.nf_f;
    assign pll_no_field = r_q.no_f;
    assign pll_bw_field = r_q.bw_f;

endmodule

// File: rtl/pll_reprog_seq_chk.sv
module pll_reprog_seq_chk #(
    parameter int NR_W = 6,
    parameter int NF_W = 13,
    parameter int NO_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            pll_lock,
    input logic            busy,
    input logic            done,
    input logic            err,
    input logic [1:0]      pll_mode,
    input logic            pll_reset,
    input logic [NR_W-1:0] pll_nr_field,
    input logic [NF_W-1:0] pll_nf_field,
    input logic [NO_W-1:0] pll_no_field,
    input logic [NF_W-2:0] pll_bw_field
);

    logic [NF_W:0]   nf_true;
    logic [NF_W-1:0] bw_full;
    assign nf_true = {1'b0, pll_nf_field} + {{NF_W{1'b0}}, 1'b1};
    assign bw_full = nf_true[NF_W:1] - {{(NF_W-1){1'b0}}, 1'b1};

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        pll_mode == 2'd0 || pll_mode == 2'd1); // R1

    AST_START_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> pll_reset && pll_mode == 2'd0 && !err); // R2

    AST_FIELDS_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(pll_nr_field) && $stable(pll_nf_field) && $stable(pll_no_field))
        |-> pll_reset && $past(pll_reset)); // R3

    AST_BW_MATCHES_NF: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pll_nf_field) |-> pll_bw_field == bw_full[NF_W-2:0]); // R4

    AST_PLL_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_mode == 2'd1) |-> $past(pll_lock) && !pll_reset && done); // R6

    AST_ERR_KEEPS_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> pll_mode == 2'd0); // R7

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy)); // R9

endmodule

bind pll_reprog_seq pll_reprog_seq_chk #(.NR_W(NR_W), .NF_W(NF_W), .NO_W(NO_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pll_lock     (pll_lock),
    .busy         (busy),
    .done         (done),
    .err          (err),
    .pll_mode     (pll_mode),
    .pll_reset    (pll_reset),
    .pll_nr_field (pll_nr_field),
    .pll_nf_field (pll_nf_field),
    .pll_no_field (pll_no_field),
    .pll_bw_field (pll_bw_field)
);

// File: tb/sim_pll_reprog_seq.sv
module sim_pll_reprog_seq;

    localparam int CLK_PERIOD = 10;
    localparam int NR_W = 6;
    localparam int NF_W = 13;
    localparam int NO_W = 4;
    localparam int TO_W = 16;
    localparam int SETTLE_CYC = 240;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [NR_W-1:0] nr_in = '0;
    logic [NF_W-1:0] nf_in = '0;
    logic [NO_W-1:0] no_in = '0;
    logic [TO_W-1:0] lock_timeout = '0;
    logic            pll_lock;
    logic            busy, done, err, pll_reset;
    logic [1:0]      pll_mode;
    logic [NR_W-1:0] pll_nr_field;
    logic [NF_W-1:0] pll_nf_field;
    logic [NO_W-1:0] pll_no_field;
    logic [NF_W-2:0] pll_bw_field;

    int checks = 0;
    int fails = 0;
    int lock_dly = 0;
    int lk_cnt = 0;
    int prev_nr = 0, prev_nf = 0, prev_no = 0, prev_bw = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // lock model: lock appears lock_dly cycles after reset is released
    always @(posedge clk) begin
        if (pll_reset) lk_cnt <= 0;
        else if (lk_cnt < 100000) lk_cnt <= lk_cnt + 1;
    end
    assign pll_lock = !pll_reset && (lk_cnt >= lock_dly);

    pll_reprog_seq #(
        .NR_W(NR_W), .NF_W(NF_W), .NO_W(NO_W), .TO_W(TO_W), .SETTLE_CYC(SETTLE_CYC)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .nr_in(nr_in), .nf_in(nf_in), .no_in(no_in), .lock_timeout(lock_timeout),
        .pll_lock(pll_lock), .busy(busy), .done(done), .err(err),
        .pll_mode(pll_mode), .pll_reset(pll_reset),
        .pll_nr_field(pll_nr_field), .pll_nf_field(pll_nf_field),
        .pll_no_field(pll_no_field), .pll_bw_field(pll_bw_field)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_seq(input int nr, input int nf, input int no,
                           input int to, input int dly, input bit glitch);
        int n;
        int m;
        int exp_m;
        bit exp_lock;
        @(negedge clk);
        start = 1'b1;
        nr_in = NR_W'(nr); nf_in = NF_W'(nf); no_in = NO_W'(no);
        lock_timeout = TO_W'(to);
        lock_dly = dly;
        @(negedge clk);
        start = 1'b0;
        nr_in = '1; nf_in = '1; no_in = '1; lock_timeout = '0;
        chk("R2 busy", busy, 1);
        chk("R2 reset", pll_reset, 1);
        chk("R2 mode", pll_mode, 0);
        chk("R2 err cleared", err, 0);
        chk("R2 nr unchanged", pll_nr_field, prev_nr);
        chk("R2 nf unchanged", pll_nf_field, prev_nf);
        @(negedge clk);
        chk("R3 nr field", pll_nr_field, nr - 1);
        chk("R3 nf field", pll_nf_field, nf - 1);
        chk("R3 no field", pll_no_field, no - 1);
        chk("R3 reset held", pll_reset, 1);
        chk("R4 bw field", pll_bw_field, (nf >> 1) - 1);
        n = 0;
        while (pll_reset === 1'b1 && n < SETTLE_CYC + 20) begin
            if (glitch && n == 3) begin
                start = 1'b1; nr_in = 6'd9; nf_in = 13'd9; no_in = 4'd9;
            end
            @(negedge clk);
            start = 1'b0;
            n++;
        end
        chk("R5 settle length", n, SETTLE_CYC);
        chk("R5 busy in wait", busy, 1);
        chk("R8 nr after ignored start", pll_nr_field, nr - 1);
        chk("R8 no after ignored start", pll_no_field, no - 1);
        m = 0;
        while (done !== 1'b1 && m < to + 20) begin
            @(negedge clk);
            m++;
        end
        exp_lock = (dly <= to);
        exp_m = exp_lock ? dly + 1 : to + 1;
        if (exp_lock) begin
            chk("R6 lock edge", m, exp_m);
            chk("R6 mode pll", pll_mode, 1);
            chk("R6 no err", err, 0);
        end else begin
            chk("R7 timeout edge", m, exp_m);
            chk("R7 mode bypass", pll_mode, 0);
            chk("R7 err set", err, 1);
        end
        chk("R9 busy low at done", busy, 0);
        @(negedge clk);
        chk("R9 done one cycle", done, 0);
        if (!exp_lock) chk("R7 err held", err, 1);
        prev_nr = nr - 1; prev_nf = nf - 1; prev_no = no - 1; prev_bw = (nf >> 1) - 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 err", err, 0);
        chk("R1 reset", pll_reset, 0);
        chk("R1 mode", pll_mode, 0);
        chk("R1 nr field", pll_nr_field, 0);
        chk("R1 nf field", pll_nf_field, 0);
        chk("R1 no field", pll_no_field, 0);
        chk("R1 bw field", pll_bw_field, 0);
        for (int nr = 1; nr <= 3; nr++)
            for (int oi = 0; oi < 2; oi++)
                for (int i = 0; i < 4; i++)
                    run_seq(nr, (i == 0) ? 2 : 37 * i + nr, 1 << (oi * 2),
                            3, (i + nr) % 5, (i == 1));
        run_seq(63, 8191, 15, 0, 0, 1'b0);   // lock on first sample
        run_seq(1, 3, 1, 0, 1, 1'b0);        // zero timeout expires
        run_seq(2, 100, 2, 7, 7, 1'b1);      // lock on the last allowed edge
        run_seq(2, 101, 2, 7, 8, 1'b0);      // one cycle too late
        run_seq(50, 4000, 8, 2, 1, 1'b0);    // recovery after error
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule